// File: doc/BRIEF.md
# Multiplexed TDM Backplane Transmit Deserializer

This block receives the system-side transmit backplane of a four-link T1/E1 framer running with all links multiplexed onto one serial stream. A serial bit clock, a frame pulse, a data line and a signaling line come in. The block runs on a faster local clock `clk` and finds the serial clock edges by oversampling. It samples the frame pulse and the two data lines on edges chosen by configuration. It then counts bit positions from the frame pulse, applying a bit offset and a timeslot offset. For every complete timeslot it emits the link number, the timeslot number within that link, the data byte and the signaling byte, together with a one-cycle strobe.

A 125 µs frame holds 1024 bits, which make 128 timeslots. Timeslot `t` of the frame belongs to link `t mod 4` and is slot `t / 4` of that link. The serial clock runs either at the bit rate or at twice the bit rate. `clk` must be at least four times the serial clock frequency. The configuration inputs are static while the block runs and may be changed during reset.

Top module: `tdm_mux_rx`

## Requirements
- R1: After reset all outputs are 0. Until the first active frame pulse has been sampled, `byte_vld` stays 0 whatever data arrives.
- R2: A frame pulse is active at level 1 when `cfg_fp_inv`=0 and at level 0 when `cfg_fp_inv`=1. Only the first active sample of a pulse counts, so a pulse two clock periods wide still starts one frame.
- R3: `cfg_fp_edge` chooses the serial clock edge that samples the frame pulse, and `cfg_data_edge` chooses the edge that samples data and signaling (0 = rising, 1 = falling). Frame bit 0 is the first data sample taken at or after the frame pulse sample. When the pulse is sampled on falling edges and data on rising edges, this bit is therefore one clock period later.
- R4: With `cfg_dbl_rate`=1 each bit spans two serial clock periods. The first period of bit 0 is the one in which frame bit 0 would fall at single rate. `cfg_dbl_sel`=0 samples the data edge of the first period of each bit, and `cfg_dbl_sel`=1 samples the data edge of the second period.
- R5: Frame bit `n` (counted from 0 at frame bit 0) is bit `(n - (8*cfg_ts_off + cfg_bit_off)) mod 1024` of the frame. `cfg_ts_off` ranges over 0..127 and `cfg_bit_off` over 0..7.
- R6: One `byte_vld` pulse is emitted per timeslot. `data_byte` holds its 8 bits with the first received bit in bit 7. For frame timeslot `t`, `link_no` = `t mod 4` and `slot_no` = `t / 4`.
- R7: `sig_byte` carries the signaling bits sampled on the same edges as the data of that timeslot, with the first received bit in bit 7.
- R8: Frame timeslot 127 is followed by timeslot 0 of the next frame. A frame pulse arriving at the expected frame boundary keeps the alignment unchanged.
- R9: A timeslot whose first bit arrived before frame bit 0 is not emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock from the backplane |
| ser_fp | input | 1 | Frame pulse |
| ser_data | input | 1 | Serial data line |
| ser_sig | input | 1 | Serial signaling line |
| cfg_fp_edge | input | 1 | Frame pulse sampling edge, 0 rising / 1 falling |
| cfg_data_edge | input | 1 | Data and signaling sampling edge, 0 rising / 1 falling |
| cfg_dbl_rate | input | 1 | 1 = serial clock at twice the bit rate |
| cfg_dbl_sel | input | 1 | In double rate: 0 first edge, 1 second edge |
| cfg_fp_inv | input | 1 | 1 = frame pulse active low |
| cfg_bit_off | input | 3 | Bit offset 0..7 |
| cfg_ts_off | input | 7 | Timeslot offset 0..127 |
| byte_vld | output | 1 | One-cycle strobe per completed timeslot |
| link_no | output | 2 | Link of the timeslot |
| slot_no | output | 5 | Timeslot index within the link |
| data_byte | output | 8 | Data byte, first bit in MSB |
| sig_byte | output | 8 | Signaling byte, first bit in MSB |

## Verification
A wrong bit position counter shows up at the first strobe after the frame pulse. That strobe then carries the wrong link or slot number, or the bytes are shifted by one bit, within eight sampled bits. A wrong edge or phase choice moves frame bit 0 by one bit, so every byte of that run comes out shifted against the scoreboard. A lost sync or primed flag shows either as strobes before the frame pulse or as a partial first byte. Each of these is caught on the first byte it affects.

// File: rtl/tdm_mux_rx.sv
module tdm_mux_rx #(
  parameter int TS_W   = 7,
  parameter int LINK_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_fp,
  input  logic                 ser_data,
  input  logic                 ser_sig,
  input  logic                 cfg_fp_edge,
  input  logic                 cfg_data_edge,
  input  logic                 cfg_dbl_rate,
  input  logic                 cfg_dbl_sel,
  input  logic                 cfg_fp_inv,
  input  logic [2:0]           cfg_bit_off,
  input  logic [TS_W-1:0]      cfg_ts_off,
  output logic                 byte_vld,
  output logic [LINK_W-1:0]    link_no,
  output logic [TS_W-LINK_W-1:0] slot_no,
  output logic [7:0]           data_byte,
  output logic [7:0]           sig_byte
);
  localparam int POS_W = TS_W + 3;

  logic [3:0] s1, s2;
  logic       sc3;
  logic       fp_prev, pend, ph, ld, synced, primed;
  logic [POS_W-1:0] cnt;
  logic [6:0] dsh, ssh;

  wire rise    = s2[3] & ~sc3;
  wire fall    = ~s2[3] & sc3;
  wire fp_ev   = cfg_fp_edge ? fall : rise;
  wire d_ev    = cfg_data_edge ? fall : rise;
  wire fp_lvl  = s2[2] ^ cfg_fp_inv;
  wire fp_hit  = fp_ev & fp_lvl & ~fp_prev;
  wire start   = (fp_hit & d_ev) | (pend & d_ev);
  wire ph_cur  = start ? 1'b0 : ph;
  wire take    = d_ev & (~cfg_dbl_rate | (ph_cur == cfg_dbl_sel));
  wire ld_cur  = start | ld;
  wire sync_c  = synced | start;
  wire [POS_W-1:0] off = {cfg_ts_off, cfg_bit_off};
  wire [POS_W-1:0] pos = ld_cur ? (~off + 1'b1) : cnt;
  wire tk      = take & sync_c;
  wire prim_c  = primed | (pos[2:0] == 3'd0);
  wire emit    = tk & (pos[2:0] == 3'd7) & prim_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; sc3 <= 1'b0;
      fp_prev <= 1'b0; pend <= 1'b0; ph <= 1'b0; ld <= 1'b0;
      synced <= 1'b0; primed <= 1'b0; cnt <= '0; dsh <= '0; ssh <= '0;
      byte_vld <= 1'b0; link_no <= '0; slot_no <= '0;
      data_byte <= '0; sig_byte <= '0;
    end else begin
      s1  <= {ser_clk, ser_fp, ser_data, ser_sig};
      s2  <= s1;
      sc3 <= s2[3];
      if (fp_ev) fp_prev <= fp_lvl;
      if (d_ev) pend <= 1'b0;
      else if (fp_hit) pend <= 1'b1;
      if (start) synced <= 1'b1;
      if (d_ev) begin
        ph <= ~ph_cur;
        ld <= take ? 1'b0 : ld_cur;
      end
      if (tk) begin
        cnt    <= pos + 1'b1;
        primed <= prim_c;
        dsh    <= {dsh[5:0], s2[1]};
        ssh    <= {ssh[5:0], s2[0]};
      end
      byte_vld <= emit;
      if (emit) begin
        link_no   <= pos[LINK_W+2:3];
        slot_no   <= pos[POS_W-1:LINK_W+3];
        data_byte <= {dsh, s2[1]};
        sig_byte  <= {ssh, s2[0]};
      end
    end
  end

  AST_NO_VLD_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |=> !byte_vld); // R1
  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced); // R1
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R6
  AST_VLD_NEEDS_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> primed); // R9
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ld); // R3
endmodule

// File: tb/tdm_mux_rx_test.sv
module tdm_mux_rx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_fp = 1'b0, ser_data = 1'b0, ser_sig = 1'b0;
  logic c_fpe = 1'b0, c_de = 1'b0, c_dbl = 1'b0, c_sel = 1'b0, c_inv = 1'b0;
  logic [2:0] c_boff = '0;
  logic [6:0] c_toff = '0;
  logic byte_vld;
  logic [1:0] link_no;
  logic [4:0] slot_no;
  logic [7:0] data_byte, sig_byte;

  int checks = 0, failures = 0, nrecv = 0;
  logic [22:0] expq[$];
  string cur_req = "R6";

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_mux_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_fp(ser_fp),
    .ser_data(ser_data), .ser_sig(ser_sig), .cfg_fp_edge(c_fpe),
    .cfg_data_edge(c_de), .cfg_dbl_rate(c_dbl), .cfg_dbl_sel(c_sel),
    .cfg_fp_inv(c_inv), .cfg_bit_off(c_boff), .cfg_ts_off(c_toff),
    .byte_vld(byte_vld), .link_no(link_no), .slot_no(slot_no),
    .data_byte(data_byte), .sig_byte(sig_byte)
  );

  function automatic logic dbit(int n);
    logic [31:0] h = n * 32'h9E3779B1;
    return h[17];
  endfunction
  function automatic logic sbit(int n);
    logic [31:0] h = n * 32'h9E3779B1 + 32'h1234;
    return h[23];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      nrecv++;
      if (expq.size() == 0) check({cur_req, " unexpected byte"}, {9'd0, link_no, slot_no, data_byte, sig_byte}, 32'hFFFFFFFF);
      else check(cur_req, {9'd0, link_no, slot_no, data_byte, sig_byte}, {9'd0, expq.pop_front()});
    end
  end

  task automatic do_reset(logic fpe, logic de, logic dbl, logic sel, logic inv, int toff, int boff);
    rst_n = 1'b0;
    c_fpe = fpe; c_de = de; c_dbl = dbl; c_sel = sel; c_inv = inv;
    c_toff = toff[6:0]; c_boff = boff[2:0];
    ser_clk = 1'b0; ser_fp = inv; ser_data = 1'b0; ser_sig = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // F < 0 means no frame pulse; rep adds a second pulse one frame later
  task automatic run(string req, logic fpe, logic de, logic dbl, logic sel, logic inv,
                     int toff, int boff, int nbits, int F, bit rep);
    int cpb = dbl ? 2 : 1;
    int ahead = (fpe && !de) ? 1 : 0;
    int b0 = F + (dbl ? (ahead & int'(sel)) : ahead);
    int off = toff * 8 + boff;
    int nexp = 0;
    cur_req = req;
    do_reset(fpe, de, dbl, sel, inv, toff, boff);
    nrecv = 0;
    if (F >= 0) begin
      for (int n = 7; b0 + n < nbits; n++) begin
        int pos = (n - off) & 1023;
        if ((pos & 7) == 7) begin
          logic [7:0] d = '0, s = '0;
          for (int k = 0; k < 8; k++) begin
            d = {d[6:0], dbit(b0 + n - 7 + k)};
            s = {s[6:0], sbit(b0 + n - 7 + k)};
          end
          expq.push_back({pos[4:3], pos[9:5], d, s});
          nexp++;
        end
      end
    end
    for (int c = 0; c < nbits * cpb; c++) begin
      int b = c / cpb;
      int bn = (c + 1) / cpb;
      logic fpc = ((F >= 0) && (b == F || (rep && b == F + 1024))) ^ inv;
      logic fpn = ((F >= 0) && (bn == F || (rep && bn == F + 1024))) ^ inv;
      if (c == 0) begin
        if (!fpe) ser_fp = fpc;
        if (!de) begin ser_data = dbit(b); ser_sig = sbit(b); end
        @(negedge clk);
      end
      ser_clk = 1'b1;
      if (fpe) ser_fp = fpc;
      if (de) begin ser_data = dbit(b); ser_sig = sbit(b); end
      repeat (2) @(negedge clk);
      ser_clk = 1'b0;
      if (!fpe) ser_fp = fpn;
      if (!de) begin ser_data = dbit(bn); ser_sig = sbit(bn); end
      repeat (2) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    check({req, " byte count"}, nrecv, nexp);
    check({req, " queue drained"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    do_reset(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    check("R1 reset vld", byte_vld, 0);
    check("R1 reset outputs", {link_no, slot_no, data_byte, sig_byte}, 0);
    run("R1 no pulse", 0, 0, 0, 0, 0, 0, 0, 120, -1, 0);
    run("R6 R7 basic", 0, 0, 0, 0, 0, 0, 0, 200, 5, 0);
    run("R3 fp ahead", 1, 0, 0, 0, 0, 3, 5, 220, 9, 0);
    run("R3 R2 data falling inverted", 0, 1, 0, 0, 1, 10, 2, 260, 4, 0);
    run("R4 dbl first edge", 0, 0, 1, 0, 0, 1, 0, 150, 3, 0);
    run("R4 R9 dbl second edge", 0, 0, 1, 1, 0, 2, 7, 150, 6, 0);
    run("R4 R2 dbl ahead second inverted", 1, 0, 1, 1, 1, 127, 3, 160, 2, 0);
    run("R5 R8 wrap and repeat pulse", 1, 1, 0, 0, 0, 0, 1, 1100, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog %s actual=running expected=done", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule